// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits beside a small processor core and decides, once per clock (one machine cycle), whether to divert execution to an interrupt handler. It watches four request sources: a timer 0 overflow, a timer 1 overflow, a serial event and a timer 2 event. It weighs them against an enable register and a priority register, and against the level already being serviced. When a request wins, it reports the handler's vector address and pulses a clear strobe for the timer flags that must drop on acceptance. It then writes the current program counter onto a byte-wide stack through a memory write port and hands back the updated stack pointer.

Two service levels exist. A high-level request can preempt a low-level handler, but nothing preempts a high-level handler. The core tells the block that a handler has finished by pulsing a return strobe, which lowers the level in service by one step.

Top module: `irq_arbiter`

## Requirements
- R1: After reset no level is in service (`lvl_busy` = 00), and `vec_valid`, `stk_we`, `sp_we`, `clr_t0_req` and `clr_t1_req` are all 0.
- R2: While bit 7 of `irq_en` (global enable) is 0, no request is accepted.
- R3: A request whose priority bit is set (high level) wins over any low-level request present in the same cycle.
- R4: Within one level, sources are polled in the fixed order timer 0, timer 1, serial, timer 2, and the first pending one wins.
- R5: A source takes part only when its enable bit in `irq_en` is set. Its level is high when its bit in `irq_pri` is set, and low otherwise. The bits are 1 for timer 0, 3 for timer 1, 4 for serial and 5 for timer 2, in both registers.
- R6: The request lines are `tmr_ctl` bit 5 (timer 0), `tmr_ctl` bit 7 (timer 1), the OR of `ser_stat` bits 0 and 1 (serial), and `t2_ctl` bit 7 (timer 2). The vectors are 0x000B, 0x001B, 0x0023 and 0x002B respectively, shown on `vec_addr` while `vec_valid` is high for one cycle after the accepting edge.
- R7: Acceptance of timer 0 pulses `clr_t0_req`, and acceptance of timer 1 pulses `clr_t1_req`, in the same cycle as `vec_valid`. Serial and timer 2 acceptances pulse neither strobe.
- R8: With stack pointer S and program counter P sampled at the accepting edge, the cycle with `vec_valid` writes P[7:0] to address S+1. The next cycle writes P[15:8] to address S+2 and presents S+2 on `sp_wdata` with `sp_we` high. Addresses wrap modulo 256.
- R9: The accepted level is recorded in `lvl_busy` (bit 1 for high, bit 0 for low). A low request is taken only when no level is active. A high request is taken only when the high level is not active.
- R10: During the cycle that writes the high byte, no request is evaluated. A request present only in that cycle is never taken.
- R11: A pulse on `ret_strobe` clears the high level if it is active, and otherwise clears the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 8 | Enable register (bit 7 global, bits 1/3/4/5 per source) |
| irq_pri | input | 8 | Priority register (bits 1/3/4/5 per source) |
| tmr_ctl | input | 8 | Timer control register; bits 5 and 7 are timer requests |
| ser_stat | input | 8 | Serial status; bits 0 and 1 raise the serial request |
| t2_ctl | input | 8 | Timer 2 control; bit 7 is the timer 2 request |
| ret_strobe | input | 1 | Handler finished; pop one service level |
| pc_now | input | 16 | Return address to be stacked |
| sp_now | input | 8 | Current stack pointer |
| vec_valid | output | 1 | One-cycle pulse: an interrupt was accepted |
| vec_addr | output | 16 | Handler vector of the accepted source |
| clr_t0_req | output | 1 | Clear strobe for the timer 0 request flag |
| clr_t1_req | output | 1 | Clear strobe for the timer 1 request flag |
| stk_we | output | 1 | Stack memory write enable |
| stk_addr | output | 8 | Stack memory write address |
| stk_wdata | output | 8 | Stack memory write data |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_wdata | output | 8 | New stack pointer value |
| lvl_busy | output | 2 | Levels in service: bit 1 high, bit 0 low |

## Verification
The hardest situation to reach is a request that appears only during the high-byte push cycle. It must be dropped, not taken a cycle late. The bench accepts a low timer 0 request, then raises a high timer 1 request for exactly that one cycle and removes it. It then checks that no vector follows and that only the low level is recorded. Nested service is reached by holding a low handler open and then raising requests at both levels, and the return strobe is walked back down through both levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC   = 4;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int SRC_T0 = 0;
  localparam int SRC_T1 = 1;

  typedef enum logic {ST_IDLE, ST_PUSH_HI} stk_st_e;

  // enable / priority bit owned by each source, in polling order
  function automatic int src_bit(input int k);
    case (k)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  // handler entry point sits 3 bytes into the 8-byte slot of the bit index
  function automatic int src_vec(input int k);
    return 8 * src_bit(k) + 3;
  endfunction
endpackage

// File: rtl/irq_select.sv
module irq_select #(
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7
) (
  input  logic [irq_pkg::NSRC-1:0]  req,
  input  logic [REG_W-1:0]          en,
  input  logic [REG_W-1:0]          pri,
  input  logic [1:0]                lvl,
  output logic                      take,
  output logic                      take_hi,
  output logic [irq_pkg::IDX_W-1:0] take_idx
);
  localparam int NSRC  = irq_pkg::NSRC;
  localparam int IDX_W = irq_pkg::IDX_W;

  logic [NSRC-1:0] cand_hi, cand_lo;
  logic            allow_hi, allow_lo;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam int B = irq_pkg::src_bit(k);
    assign cand_hi[k] = req[k] & en[B] &  pri[B];
    assign cand_lo[k] = req[k] & en[B] & ~pri[B];
  end

  assign allow_hi = en[GIE_BIT] & ~lvl[1];
  assign allow_lo = en[GIE_BIT] & (lvl == 2'b00);

  always_comb begin
    take     = 1'b0;
    take_hi  = 1'b0;
    take_idx = '0;
    // descending scans: the last hit (lowest index) wins; high scan overrides low
    if (allow_lo) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (cand_lo[i]) begin
          take     = 1'b1;
          take_hi  = 1'b0;
          take_idx = IDX_W'(i);
        end
      end
    end
    if (allow_hi) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (cand_hi[i]) begin
          take     = 1'b1;
          take_hi  = 1'b1;
          take_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/irq_level.sv
module irq_level (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic       acc_hi,
  input  logic       pop,
  output logic [1:0] lvl
);
  logic [1:0] after_pop;

  always_comb begin
    after_pop = lvl;
    if (pop) after_pop = lvl[1] ? {1'b0, lvl[0]} : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst)         lvl <= 2'b00;
    else if (accept) lvl <= after_pop | (acc_hi ? 2'b10 : 2'b01);
    else             lvl <= after_pop;
  end
endmodule

// File: rtl/irq_stacker.sv
module irq_stacker #(
  parameter int SP_W   = 8,
  parameter int BYTE_W = 8,
  localparam int PC_W  = 2 * BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic [irq_pkg::IDX_W-1:0] idx,
  input  logic [PC_W-1:0]           pc_now,
  input  logic [SP_W-1:0]           sp_now,
  output logic                      busy,
  output logic                      vec_valid,
  output logic [PC_W-1:0]           vec_addr,
  output logic                      clr_t0,
  output logic                      clr_t1,
  output logic                      stk_we,
  output logic [SP_W-1:0]           stk_addr,
  output logic [BYTE_W-1:0]         stk_wdata,
  output logic                      sp_we,
  output logic [SP_W-1:0]           sp_wdata
);
  import irq_pkg::*;

  stk_st_e          st;
  logic [BYTE_W-1:0] hi_byte;
  logic [PC_W-1:0]   vtab [NSRC];

  for (genvar k = 0; k < NSRC; k++) begin : g_vec
    assign vtab[k] = PC_W'(src_vec(k));
  end

  assign busy = (st == ST_PUSH_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      vec_valid <= 1'b0;
      vec_addr  <= '0;
      clr_t0    <= 1'b0;
      clr_t1    <= 1'b0;
      stk_we    <= 1'b0;
      stk_addr  <= '0;
      stk_wdata <= '0;
      sp_we     <= 1'b0;
      sp_wdata  <= '0;
      hi_byte   <= '0;
    end else begin
      vec_valid <= 1'b0;
      clr_t0    <= 1'b0;
      clr_t1    <= 1'b0;
      stk_we    <= 1'b0;
      sp_we     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            vec_valid <= 1'b1;
            vec_addr  <= vtab[idx];
            clr_t0    <= (idx == IDX_W'(SRC_T0));
            clr_t1    <= (idx == IDX_W'(SRC_T1));
            stk_we    <= 1'b1;
            stk_addr  <= sp_now + SP_W'(1);
            stk_wdata <= pc_now[BYTE_W-1:0];
            hi_byte   <= pc_now[PC_W-1:BYTE_W];
            st        <= ST_PUSH_HI;
          end
        end
        default: begin
          stk_we    <= 1'b1;
          stk_addr  <= stk_addr + SP_W'(1);
          stk_wdata <= hi_byte;
          sp_we     <= 1'b1;
          sp_wdata  <= stk_addr + SP_W'(1);
          st        <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7,
  parameter int SP_W    = 8,
  parameter int BYTE_W  = 8,
  localparam int PC_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  irq_en,
  input  logic [REG_W-1:0]  irq_pri,
  input  logic [REG_W-1:0]  tmr_ctl,
  input  logic [REG_W-1:0]  ser_stat,
  input  logic [REG_W-1:0]  t2_ctl,
  input  logic              ret_strobe,
  input  logic [PC_W-1:0]   pc_now,
  input  logic [SP_W-1:0]   sp_now,
  output logic              vec_valid,
  output logic [PC_W-1:0]   vec_addr,
  output logic              clr_t0_req,
  output logic              clr_t1_req,
  output logic              stk_we,
  output logic [SP_W-1:0]   stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              sp_we,
  output logic [SP_W-1:0]   sp_wdata,
  output logic [1:0]        lvl_busy
);
  import irq_pkg::*;

  logic [NSRC-1:0]  req;
  logic             take, take_hi, busy, accept;
  logic [IDX_W-1:0] take_idx;

  // request lines in polling order
  assign req[0] = tmr_ctl[5];
  assign req[1] = tmr_ctl[7];
  assign req[2] = ser_stat[0] | ser_stat[1];
  assign req[3] = t2_ctl[7];

  assign accept = take & ~busy;

  irq_select #(.REG_W(REG_W), .GIE_BIT(GIE_BIT)) u_sel (
    .req(req), .en(irq_en), .pri(irq_pri), .lvl(lvl_busy),
    .take(take), .take_hi(take_hi), .take_idx(take_idx)
  );

  irq_level u_lvl (
    .clk(clk), .rst(rst), .accept(accept), .acc_hi(take_hi),
    .pop(ret_strobe), .lvl(lvl_busy)
  );

  irq_stacker #(.SP_W(SP_W), .BYTE_W(BYTE_W)) u_stk (
    .clk(clk), .rst(rst), .accept(accept), .idx(take_idx),
    .pc_now(pc_now), .sp_now(sp_now), .busy(busy),
    .vec_valid(vec_valid), .vec_addr(vec_addr),
    .clr_t0(clr_t0_req), .clr_t1(clr_t1_req),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int REG_W   = 8,
  parameter int GIE_BIT = 7,
  parameter int SP_W    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] irq_en,
  input logic             ret_strobe,
  input logic             vec_valid,
  input logic             clr_t0_req,
  input logic             clr_t1_req,
  input logic             stk_we,
  input logic [SP_W-1:0]  stk_addr,
  input logic             sp_we,
  input logic [1:0]       lvl_busy
);
  // R2
  glob_off_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en[GIE_BIT] |=> !vec_valid);

  // R10
  push_gap_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> !vec_valid);

  // R8
  push_lo_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (stk_we && !sp_we));

  // R8
  push_hi_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |=> (stk_we && sp_we && stk_addr == $past(stk_addr) + SP_W'(1)));

  // R7
  clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_t0_req || clr_t1_req) |-> (vec_valid && !(clr_t0_req && clr_t1_req)));

  // R9
  nest_block_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_busy[1] && !vec_valid) |=> !vec_valid);

  // R11
  ret_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (ret_strobe && lvl_busy[1]) |=> (!lvl_busy[1] && lvl_busy[0] == $past(lvl_busy[0])));
endmodule

bind irq_arbiter irq_arbiter_chk #(.REG_W(REG_W), .GIE_BIT(GIE_BIT), .SP_W(SP_W)) u_chk (
  .clk(clk), .rst(rst), .irq_en(irq_en), .ret_strobe(ret_strobe),
  .vec_valid(vec_valid), .clr_t0_req(clr_t0_req), .clr_t1_req(clr_t1_req),
  .stk_we(stk_we), .stk_addr(stk_addr), .sp_we(sp_we), .lvl_busy(lvl_busy)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_en = '0, irq_pri = '0, tmr_ctl = '0, ser_stat = '0, t2_ctl = '0;
  logic        ret_strobe = 1'b0;
  logic [15:0] pc_now = '0;
  logic [7:0]  sp_now = '0;
  logic        vec_valid, clr_t0_req, clr_t1_req, stk_we, sp_we;
  logic [15:0] vec_addr;
  logic [7:0]  stk_addr, stk_wdata, sp_wdata;
  logic [1:0]  lvl_busy;

  int total = 0;
  int bad   = 0;

  always #(CLK_PER / 2) clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst(rst), .irq_en(irq_en), .irq_pri(irq_pri),
    .tmr_ctl(tmr_ctl), .ser_stat(ser_stat), .t2_ctl(t2_ctl),
    .ret_strobe(ret_strobe), .pc_now(pc_now), .sp_now(sp_now),
    .vec_valid(vec_valid), .vec_addr(vec_addr),
    .clr_t0_req(clr_t0_req), .clr_t1_req(clr_t1_req),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .lvl_busy(lvl_busy)
  );

  typedef struct packed {
    logic [7:0]  en;
    logic [7:0]  pri;
    logic [7:0]  tc;
    logic [7:0]  ss;
    logic [7:0]  t2;
    logic        v;
    logic [15:0] vec;
    logic [1:0]  lvl;
  } row_t;

  localparam int NROW = 10;
  localparam row_t ROWS [NROW] = '{
    '{8'h3A, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 16'h0000, 2'b00}, // R2 global off
    '{8'hBA, 8'h00, 8'h20, 8'h00, 8'h00, 1'b1, 16'h000B, 2'b01}, // R6 timer 0
    '{8'hBA, 8'h00, 8'h80, 8'h00, 8'h00, 1'b1, 16'h001B, 2'b01}, // R6 timer 1
    '{8'hBA, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 16'h0023, 2'b01}, // R6 serial bit 0
    '{8'hBA, 8'h00, 8'h00, 8'h02, 8'h80, 1'b1, 16'h0023, 2'b01}, // R4 serial before timer 2
    '{8'hBA, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1, 16'h002B, 2'b01}, // R6 timer 2
    '{8'hBA, 8'h20, 8'h20, 8'h00, 8'h80, 1'b1, 16'h002B, 2'b10}, // R3 high over low
    '{8'hBA, 8'h00, 8'hA0, 8'h01, 8'h00, 1'b1, 16'h000B, 2'b01}, // R4 order low
    '{8'hB8, 8'h00, 8'hA0, 8'h00, 8'h00, 1'b1, 16'h001B, 2'b01}, // R5 disabled t0 skipped
    '{8'hBA, 8'h10, 8'h80, 8'h01, 8'h00, 1'b1, 16'h0023, 2'b10}  // R5 priority bit 4
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    irq_en = '0; irq_pri = '0; tmr_ctl = '0; ser_stat = '0; t2_ctl = '0;
    ret_strobe = 1'b0;
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(lvl_busy == 2'b00, "R1 lvl", lvl_busy, 0);
    chk(!vec_valid && !stk_we && !sp_we && !clr_t0_req && !clr_t1_req, "R1 strobes",
        {vec_valid, stk_we, sp_we, clr_t0_req, clr_t1_req}, 0);

    for (int r = 0; r < NROW; r++) begin
      do_reset();
      irq_en = ROWS[r].en; irq_pri = ROWS[r].pri; tmr_ctl = ROWS[r].tc;
      ser_stat = ROWS[r].ss; t2_ctl = ROWS[r].t2;
      step();
      chk(vec_valid == ROWS[r].v, $sformatf("R2/R6 row%0d valid", r), vec_valid, ROWS[r].v);
      if (ROWS[r].v)
        chk(vec_addr == ROWS[r].vec, $sformatf("R3/R4/R5/R6 row%0d vector", r), vec_addr, ROWS[r].vec);
      chk(lvl_busy == ROWS[r].lvl, $sformatf("R9 row%0d level", r), lvl_busy, ROWS[r].lvl);
      clear_in();
      step();
    end

    // R8 R7: push sequence with timer 0
    do_reset();
    sp_now = 8'h07; pc_now = 16'h1234;
    irq_en = 8'hBA; tmr_ctl = 8'h20;
    step();
    tmr_ctl = 8'h00;
    chk(stk_we && stk_addr == 8'h08 && stk_wdata == 8'h34 && !sp_we, "R8 low byte push",
        {stk_addr, stk_wdata}, 16'h0834);
    chk(clr_t0_req && !clr_t1_req, "R7 timer0 clear", {clr_t0_req, clr_t1_req}, 2'b10);
    step();
    chk(stk_we && stk_addr == 8'h09 && stk_wdata == 8'h12, "R8 high byte push",
        {stk_addr, stk_wdata}, 16'h0912);
    chk(sp_we && sp_wdata == 8'h09, "R8 stack pointer", sp_wdata, 8'h09);
    chk(!clr_t0_req && !vec_valid, "R7 clear is one pulse", clr_t0_req, 0);

    // R9 nesting: low active blocks low, admits high
    irq_pri = 8'h00; tmr_ctl = 8'h80;
    step();
    step();
    chk(!vec_valid && lvl_busy == 2'b01, "R9 low blocked by low", {vec_valid, lvl_busy}, 3'b001);
    irq_pri = 8'h08;
    step();
    chk(vec_valid && vec_addr == 16'h001B && lvl_busy == 2'b11, "R9 high preempts low",
        vec_addr, 16'h001B);
    chk(clr_t1_req && !clr_t0_req, "R7 timer1 clear", {clr_t0_req, clr_t1_req}, 2'b01);
    tmr_ctl = 8'h00;
    step();
    irq_pri = 8'h0A; tmr_ctl = 8'h20;
    step();
    step();
    chk(!vec_valid && lvl_busy == 2'b11, "R9 high blocked by high", {vec_valid, lvl_busy}, 3'b011);
    tmr_ctl = 8'h00;
    ret_strobe = 1'b1;
    step();
    chk(lvl_busy == 2'b01, "R11 pop high", lvl_busy, 2'b01);
    step();
    ret_strobe = 1'b0;
    chk(lvl_busy == 2'b00, "R11 pop low", lvl_busy, 2'b00);

    // R7: serial and timer 2 give no clear strobe
    do_reset();
    irq_en = 8'hBA; ser_stat = 8'h02;
    step();
    chk(vec_valid && !clr_t0_req && !clr_t1_req, "R7 serial no clear",
        {vec_valid, clr_t0_req, clr_t1_req}, 3'b100);
    do_reset();
    irq_en = 8'hBA; t2_ctl = 8'h80;
    step();
    chk(vec_valid && !clr_t0_req && !clr_t1_req, "R7 timer2 no clear",
        {vec_valid, clr_t0_req, clr_t1_req}, 3'b100);

    // R8: stack address wrap
    do_reset();
    sp_now = 8'hFF; pc_now = 16'hABCD;
    irq_en = 8'hBA; tmr_ctl = 8'h20;
    step();
    tmr_ctl = 8'h00;
    chk(stk_addr == 8'h00 && stk_wdata == 8'hCD, "R8 wrap low", {stk_addr, stk_wdata}, 16'h00CD);
    step();
    chk(stk_addr == 8'h01 && stk_wdata == 8'hAB && sp_wdata == 8'h01, "R8 wrap high",
        {stk_addr, sp_wdata}, 16'h0101);

    // R10: request seen only during the high-byte push is dropped
    do_reset();
    sp_now = 8'h20;
    irq_en = 8'hBA; irq_pri = 8'h08; tmr_ctl = 8'h20;
    step();
    chk(vec_valid && vec_addr == 16'h000B, "R10 first accept", vec_addr, 16'h000B);
    tmr_ctl = 8'h80;
    step();
    chk(!vec_valid, "R10 no accept in push", vec_valid, 0);
    tmr_ctl = 8'h00;
    step();
    chk(!vec_valid && lvl_busy == 2'b01, "R10 request dropped", {vec_valid, lvl_busy}, 3'b001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule